// File: doc/BRIEF.md
# Byte Memory DMA Controller

This controller copies a block of words between an 8-bit external byte memory and on-chip word memories. The processor keeps running meanwhile. Software supplies a format code, a direction, a starting byte address, a starting word address and a word count, then pulses a start strobe. For each word, the controller runs one, two or three byte accesses on the external bus. In the inbound direction it gathers those bytes into a word and then asks for a single internal memory cycle. In the outbound direction it first fetches the word in one internal cycle and then sends its bytes out one at a time.

The external byte address is 22 bits wide. Its upper 8 bits are driven on a page output, which the board routes to the top byte of the data bus. Its lower 14 bits go on the address lines. Every byte strobe is stretched by a configurable number of wait cycles. The internal side uses a request/grant handshake, and the controller holds its request steady until the grant comes. When the last word completes, a sticky done flag is set and a one-cycle interrupt pulse is issued.

Top module: `bytedma_ctrl`

## Requirements
- R1: After reset the controller is idle: busy, done, irq, bm_rd, bm_wr and mem_req are all 0.
- R2: In the inbound direction (cfg_to_ext=0), bytes are packed by cfg_fmt.
  - Code 00 stores three bytes, first byte into bits 23:16, then 15:8, then 7:0.
  - Code 01 stores two bytes, first into bits 15:8, then 7:0, with bits 23:16 zero.
  - Code 10 stores one byte into bits 15:8, with the rest zero.
  - Code 11 stores one byte into bits 7:0, with the rest zero.
- R3: In the outbound direction (cfg_to_ext=1), the fetched word is sent out as bytes, most significant lane first.
  - Code 00 sends bits 23:16, 15:8 and 7:0.
  - Code 01 sends bits 15:8 and 7:0.
  - Code 10 sends bits 15:8.
  - Code 11 sends bits 7:0.
- R4: The 22-bit byte address appears as {bm_page, bm_addr}. It advances by one after every byte access, with the carry from bit 13 into bit 14.
- R5: The internal word address starts at cfg_int_addr and advances by one per word. mem_pm is 1 exactly for format code 00.
- R6: Each byte strobe (bm_rd or bm_wr) is held for cfg_wait+1 cycles per byte.
- R7: Each word uses exactly one internal request. mem_req, mem_addr, mem_wdata and mem_we stay stable until mem_gnt, so a grant latency of L cycles gives L+1 request cycles per word. No byte strobe is active while mem_req is high.
- R8: Exactly cfg_words words are moved. After the last one, busy falls, done is set and irq pulses for exactly one cycle.
- R9: A start with cfg_words=0 sets done and pulses irq on the next cycle, with no bus or memory activity.
- R10: A start clears done. A start strobe that arrives while busy is ignored.
- R11: bm_rd and bm_wr are never both high. Only the strobe for the configured direction is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Start strobe; loads the configuration when idle |
| cfg_fmt | input | 2 | Packing format code |
| cfg_to_ext | input | 1 | 1: internal to byte memory; 0: byte memory to internal |
| cfg_ext_addr | input | 22 | Starting byte address |
| cfg_int_addr | input | 14 | Starting internal word address |
| cfg_words | input | CNT_W | Number of words to move |
| cfg_wait | input | WAIT_W | Wait cycles added to each byte access |
| bm_addr | output | 14 | Byte address bits 13:0 |
| bm_page | output | 8 | Byte address bits 21:14 (driven on data bits 23:16) |
| bm_rd | output | 1 | Byte read strobe |
| bm_wr | output | 1 | Byte write strobe |
| bm_wdata | output | 8 | Byte write data |
| bm_rdata | input | 8 | Byte read data |
| mem_req | output | 1 | Internal memory cycle request |
| mem_we | output | 1 | Internal cycle is a write |
| mem_pm | output | 1 | Internal cycle targets the 24-bit program memory |
| mem_addr | output | 14 | Internal word address |
| mem_wdata | output | 24 | Internal write data |
| mem_rdata | input | 24 | Internal read data, valid with the grant |
| mem_gnt | input | 1 | Internal memory grant |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A wrong byte-lane index or a stale upper lane shows up in the first word written to internal memory or in the first byte sent out. That is within one word time of the start. A wrong byte-address step or page carry corrupts the bytes fetched right after the 14-bit boundary. A mis-set wait counter changes the strobe length on the very first byte. A word-count fault shows up only at the end of the transfer: as an extra or missing word beyond the block, or as a done/irq pulse in the wrong cycle.

// File: rtl/bytedma_pkg.sv
package bytedma_pkg;

    localparam int EXT_AW = 22;
    localparam int BUS_AW = 14;
    localparam int PAGE_W = EXT_AW - BUS_AW;
    localparam int INT_AW = 14;
    localparam int BYTE_W = 8;
    localparam int LANES  = 3;
    localparam int WORD_W = BYTE_W * LANES;

    typedef enum logic [1:0] {
        FMT_PM24 = 2'b00,
        FMT_DM16 = 2'b01,
        FMT_HI8  = 2'b10,
        FMT_LO8  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BYTE = 2'd1,
        ST_MEM  = 2'd2
    } state_e;

    typedef struct packed {
        fmt_e fmt;
        logic to_ext;
    } mode_t;

    // number of byte accesses forming one word
    function automatic logic [1:0] bytes_per_word(input fmt_e f);
        case (f)
            FMT_PM24: return 2'd3;
            FMT_DM16: return 2'd2;
            default:  return 2'd1;
        endcase
    endfunction

    // word lane (2 = bits 23:16) touched by byte number idx of a word
    function automatic logic [1:0] lane_of(input fmt_e f, input logic [1:0] idx);
        case (f)
            FMT_PM24: return 2'd2 - idx;
            FMT_DM16: return 2'd1 - idx;
            FMT_HI8:  return 2'd1;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/bytedma_wait.sv
module bytedma_wait #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [WAIT_W-1:0] limit,
    output logic              last
);
    logic [WAIT_W-1:0] cnt_q;

    assign last = active && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !active || last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + WAIT_W'(1);
    end
endmodule

// File: rtl/bytedma_packer.sv
module bytedma_packer
    import bytedma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fmt_e              fmt,
    input  logic [1:0]        idx,
    input  logic              load_word,
    input  logic [WORD_W-1:0] word_in,
    input  logic              cap_byte,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [WORD_W-1:0] word_out,
    output logic [BYTE_W-1:0] byte_out
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] placed;
    logic [1:0]        lane;
    logic [BYTE_W-1:0] lane_bytes [LANES];

    assign lane = lane_of(fmt, idx);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word_q[g*BYTE_W +: BYTE_W];
        assign placed[g*BYTE_W +: BYTE_W] = (lane == 2'(g)) ? byte_in : '0;
    end

    assign byte_out = (lane < 2'(LANES)) ? lane_bytes[lane] : '0;
    assign word_out = word_q;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (load_word)
            word_q <= word_in;
        else if (cap_byte)
            word_q <= ((idx == 2'd0) ? '0 : word_q) | placed;
    end
endmodule

// File: rtl/bytedma_ctrl.sv
module bytedma_ctrl
    import bytedma_pkg::*;
#(
    parameter int WAIT_W = 3,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_start,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_to_ext,
    input  logic [21:0]       cfg_ext_addr,
    input  logic [13:0]       cfg_int_addr,
    input  logic [CNT_W-1:0]  cfg_words,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic [13:0]       bm_addr,
    output logic [7:0]        bm_page,
    output logic              bm_rd,
    output logic              bm_wr,
    output logic [7:0]        bm_wdata,
    input  logic [7:0]        bm_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_pm,
    output logic [13:0]       mem_addr,
    output logic [23:0]       mem_wdata,
    input  logic [23:0]       mem_rdata,
    input  logic              mem_gnt,
    output logic              busy,
    output logic              done,
    output logic              irq
);
    state_e             st_q;
    mode_t              mode_q;
    logic [WAIT_W-1:0]  wait_q;
    logic [EXT_AW-1:0]  ext_q;
    logic [INT_AW-1:0]  int_q;
    logic [CNT_W-1:0]   left_q;
    logic [1:0]         idx_q;
    logic               done_q, irq_q;

    logic strobe, byte_last, byte_end, last_byte, mem_go, word_end;

    assign strobe    = (st_q == ST_BYTE);
    assign byte_end  = strobe && byte_last;
    assign last_byte = (idx_q == bytes_per_word(mode_q.fmt) - 2'd1);
    assign mem_go    = (st_q == ST_MEM) && mem_gnt;
    assign word_end  = mode_q.to_ext ? (byte_end && last_byte) : mem_go;

    bytedma_wait #(.WAIT_W(WAIT_W)) u_wait (
        .clk    (clk),
        .rst    (rst),
        .active (strobe),
        .limit  (wait_q),
        .last   (byte_last)
    );

    bytedma_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .fmt       (mode_q.fmt),
        .idx       (idx_q),
        .load_word (mem_go && mode_q.to_ext),
        .word_in   (mem_rdata),
        .cap_byte  (byte_end && !mode_q.to_ext),
        .byte_in   (bm_rdata),
        .word_out  (mem_wdata),
        .byte_out  (bm_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= '{fmt: FMT_PM24, to_ext: 1'b0};
            wait_q <= '0;
            ext_q  <= '0;
            int_q  <= '0;
            left_q <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (cfg_start) begin
                        mode_q <= '{fmt: fmt_e'(cfg_fmt), to_ext: cfg_to_ext};
                        wait_q <= cfg_wait;
                        ext_q  <= cfg_ext_addr;
                        int_q  <= cfg_int_addr;
                        left_q <= cfg_words;
                        idx_q  <= '0;
                        if (cfg_words == '0) begin
                            done_q <= 1'b1;
                            irq_q  <= 1'b1;
                        end else begin
                            done_q <= 1'b0;
                            st_q   <= cfg_to_ext ? ST_MEM : ST_BYTE;
                        end
                    end
                end
                ST_BYTE: begin
                    if (byte_end) begin
                        ext_q <= ext_q + EXT_AW'(1);
                        if (!last_byte)
                            idx_q <= idx_q + 2'd1;
                        else if (!mode_q.to_ext)
                            st_q <= ST_MEM;
                    end
                end
                ST_MEM: begin
                    if (mem_go && mode_q.to_ext) begin
                        st_q  <= ST_BYTE;
                        idx_q <= '0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
            if (word_end) begin
                int_q  <= int_q + INT_AW'(1);
                left_q <= left_q - CNT_W'(1);
                idx_q  <= '0;
                if (left_q == CNT_W'(1)) begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                    irq_q  <= 1'b1;
                end else begin
                    st_q <= mode_q.to_ext ? ST_MEM : ST_BYTE;
                end
            end
        end
    end

    assign bm_addr  = ext_q[BUS_AW-1:0];
    assign bm_page  = ext_q[EXT_AW-1:BUS_AW];
    assign bm_rd    = strobe && !mode_q.to_ext;
    assign bm_wr    = strobe && mode_q.to_ext;
    assign mem_req  = (st_q == ST_MEM);
    assign mem_we   = !mode_q.to_ext;
    assign mem_pm   = (mode_q.fmt == FMT_PM24);
    assign mem_addr = int_q;
    assign busy     = (st_q != ST_IDLE);
    assign done     = done_q;
    assign irq      = irq_q;
endmodule

// File: rtl/bytedma_ctrl_chk.sv
module bytedma_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        bm_rd,
    input logic        bm_wr,
    input logic [13:0] bm_addr,
    input logic [7:0]  bm_page,
    input logic        mem_req,
    input logic        mem_gnt,
    input logic        mem_we,
    input logic [13:0] mem_addr,
    input logic [23:0] mem_wdata,
    input logic        busy,
    input logic        done,
    input logic        irq
);
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(bm_rd && bm_wr));

    a_r7_hold_req: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_wdata) && $stable(mem_we)));

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !(bm_rd || bm_wr));

    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (bm_rd || bm_wr) |=> (!(bm_rd || bm_wr)
            || ({bm_page, bm_addr} == $past({bm_page, bm_addr}))
            || ({bm_page, bm_addr} == $past({bm_page, bm_addr}) + 22'd1)));

    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r8_irq_done: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done && !busy));

    a_r10_busy_clears_done: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);
endmodule

bind bytedma_ctrl bytedma_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bm_rd     (bm_rd),
    .bm_wr     (bm_wr),
    .bm_addr   (bm_addr),
    .bm_page   (bm_page),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .irq       (irq)
);

// File: tb/bytedma_ctrl_tb.sv
`timescale 1ns/1ps
module bytedma_ctrl_tb;
    localparam int WAIT_W = 3;
    localparam int CNT_W  = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              cfg_start = 1'b0;
    logic [1:0]        cfg_fmt = 2'b00;
    logic              cfg_to_ext = 1'b0;
    logic [21:0]       cfg_ext_addr = '0;
    logic [13:0]       cfg_int_addr = '0;
    logic [CNT_W-1:0]  cfg_words = '0;
    logic [WAIT_W-1:0] cfg_wait = '0;
    logic [13:0] bm_addr;
    logic [7:0]  bm_page, bm_wdata, bm_rdata;
    logic        bm_rd, bm_wr, mem_req, mem_we, mem_pm, busy, done, irq;
    logic [13:0] mem_addr;
    logic [23:0] mem_wdata, mem_rdata;
    logic        mem_gnt = 1'b0;

    bytedma_ctrl #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_fmt(cfg_fmt),
        .cfg_to_ext(cfg_to_ext), .cfg_ext_addr(cfg_ext_addr),
        .cfg_int_addr(cfg_int_addr), .cfg_words(cfg_words), .cfg_wait(cfg_wait),
        .bm_addr(bm_addr), .bm_page(bm_page), .bm_rd(bm_rd), .bm_wr(bm_wr),
        .bm_wdata(bm_wdata), .bm_rdata(bm_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_pm(mem_pm), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .busy(busy), .done(done), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;

    function automatic logic [7:0] bsrc(input logic [21:0] a);
        return a[7:0] ^ a[21:14] ^ 8'h5A;
    endfunction
    function automatic logic [23:0] isrc(input logic [13:0] a);
        return {a[7:0] ^ 8'hC3, a[7:0] + 8'h3C, a[7:0] ^ 8'h96};
    endfunction

    assign bm_rdata  = bsrc({bm_page, bm_addr});
    assign mem_rdata = isrc(mem_addr);

    // grant model: L+1 request cycles per word
    int gnt_lat = 0;
    int gcnt = 0;
    always @(negedge clk) begin
        if (mem_gnt) begin
            mem_gnt <= 1'b0;
            gcnt    <= 0;
        end else if (mem_req) begin
            if (gcnt == gnt_lat) mem_gnt <= 1'b1;
            else gcnt <= gcnt + 1;
        end
    end

    // activity counters
    int rd_cyc = 0, wr_cyc = 0, req_cyc = 0, irq_cyc = 0;
    always @(negedge clk) begin
        if (bm_rd) rd_cyc <= rd_cyc + 1;
        if (bm_wr) wr_cyc <= wr_cyc + 1;
        if (mem_req) req_cyc <= req_cyc + 1;
        if (irq) irq_cyc <= irq_cyc + 1;
    end

    // write logs relative to bases
    logic [21:0] ebase = '0;
    logic [13:0] ibase = '0;
    logic [7:0]  wlog [16];
    logic        wval [16];
    logic [23:0] ilog [16];
    logic        isel [16];
    logic        ival [16];
    always @(posedge clk) begin
        if (bm_wr && (({bm_page, bm_addr} - ebase) < 22'd16)) begin
            wlog[4'(({bm_page, bm_addr} - ebase))] <= bm_wdata;
            wval[4'(({bm_page, bm_addr} - ebase))] <= 1'b1;
        end
        if (mem_req && mem_gnt && mem_we && ((mem_addr - ibase) < 14'd16)) begin
            ilog[4'(mem_addr - ibase)] <= mem_wdata;
            isel[4'(mem_addr - ibase)] <= mem_pm;
            ival[4'(mem_addr - ibase)] <= 1'b1;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        for (int i = 0; i < 16; i++) begin
            wval[i] = 1'b0; ival[i] = 1'b0;
        end
    endtask

    task automatic start(input logic [1:0] f, input logic dir, input logic [21:0] ea,
                         input logic [13:0] ia, input int words, input int wt);
        @(negedge clk);
        cfg_fmt = f; cfg_to_ext = dir; cfg_ext_addr = ea; cfg_int_addr = ia;
        cfg_words = CNT_W'(words); cfg_wait = WAIT_W'(wt); cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    task automatic wait_done();
        int lim = 0;
        while (!done && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        chk(done, "R8 done timeout", int'(done), 1);
        @(negedge clk);
    endtask

    function automatic int nbytes(input logic [1:0] f);
        return (f == 2'b00) ? 3 : (f == 2'b01) ? 2 : 1;
    endfunction

    function automatic logic [23:0] exp_word(input logic [1:0] f, input logic [21:0] ea, input int k);
        int nb = nbytes(f);
        logic [21:0] a = ea + 22'(k * nb);
        case (f)
            2'b00: return {bsrc(a), bsrc(a + 22'd1), bsrc(a + 22'd2)};
            2'b01: return {8'h00, bsrc(a), bsrc(a + 22'd1)};
            2'b10: return {8'h00, bsrc(a), 8'h00};
            default: return {16'h0000, bsrc(a)};
        endcase
    endfunction

    task automatic t_reset();
        chk(!busy && !done && !irq, "R1 status idle", {busy, done, irq}, 0);
        chk(!bm_rd && !bm_wr && !mem_req, "R1 strobes idle", {bm_rd, bm_wr, mem_req}, 0);
    endtask

    // inbound: byte memory -> internal (R2, R4, R5, R6, R7, R8)
    task automatic t_inbound(input logic [1:0] f, input logic [21:0] ea, input logic [13:0] ia,
                             input int words, input int wt, input int lat);
        int rd0, req0, irq0, nb;
        nb = nbytes(f);
        gnt_lat = lat; ebase = ea; ibase = ia;
        clear_logs();
        rd0 = rd_cyc; req0 = req_cyc; irq0 = irq_cyc;
        start(f, 1'b0, ea, ia, words, wt);
        wait_done();
        for (int k = 0; k < words; k++) begin
            chk(ival[k] && ilog[k] == exp_word(f, ea, k), "R2 R4 packed word",
                int'(ilog[k]), int'(exp_word(f, ea, k)));
            chk(isel[k] == (f == 2'b00), "R5 program select", int'(isel[k]), int'(f == 2'b00));
        end
        chk(!ival[words], "R8 no extra word", int'(ival[words]), 0);
        chk(rd_cyc - rd0 == words * nb * (wt + 1), "R6 read strobe cycles",
            rd_cyc - rd0, words * nb * (wt + 1));
        chk(req_cyc - req0 == words * (lat + 1), "R7 request cycles",
            req_cyc - req0, words * (lat + 1));
        chk(irq_cyc - irq0 == 1 && !busy, "R8 single irq", irq_cyc - irq0, 1);
    endtask

    // outbound: internal -> byte memory (R3, R4, R6, R11)
    task automatic t_outbound(input logic [1:0] f, input logic [21:0] ea, input logic [13:0] ia,
                              input int words, input int wt, input int lat);
        int wr0, rd0, nb;
        logic [23:0] w;
        logic [7:0]  eb;
        nb = nbytes(f);
        gnt_lat = lat; ebase = ea; ibase = ia;
        clear_logs();
        wr0 = wr_cyc; rd0 = rd_cyc;
        start(f, 1'b1, ea, ia, words, wt);
        wait_done();
        for (int k = 0; k < words; k++) begin
            w = isrc(ia + 14'(k));
            for (int b = 0; b < nb; b++) begin
                case (f)
                    2'b00: eb = (b == 0) ? w[23:16] : (b == 1) ? w[15:8] : w[7:0];
                    2'b01: eb = (b == 0) ? w[15:8] : w[7:0];
                    2'b10: eb = w[15:8];
                    default: eb = w[7:0];
                endcase
                chk(wval[k*nb+b] && wlog[k*nb+b] == eb, "R3 R4 byte out",
                    int'(wlog[k*nb+b]), int'(eb));
            end
        end
        chk(!wval[words*nb], "R8 no extra byte", int'(wval[words*nb]), 0);
        chk(wr_cyc - wr0 == words * nb * (wt + 1), "R6 write strobe cycles",
            wr_cyc - wr0, words * nb * (wt + 1));
        chk(rd_cyc == rd0, "R11 no read strobe outbound", rd_cyc - rd0, 0);
    endtask

    task automatic t_zero();
        int rd0 = rd_cyc, req0 = req_cyc, irq0 = irq_cyc;
        @(negedge clk);
        cfg_words = '0; cfg_to_ext = 1'b0; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        chk(done && irq && !busy, "R9 zero count done", {done, irq, busy}, 3'b110);
        repeat (3) @(negedge clk);
        chk(rd_cyc == rd0 && req_cyc == req0, "R9 zero count quiet",
            (rd_cyc - rd0) + (req_cyc - req0), 0);
        chk(irq_cyc - irq0 == 1, "R9 one irq", irq_cyc - irq0, 1);
    endtask

    task automatic t_restart_ignored();
        clear_logs();
        ebase = 22'h000100; ibase = 14'h0040; gnt_lat = 1;
        start(2'b01, 1'b0, 22'h000100, 14'h0040, 3, 1);
        chk(!done && busy, "R10 start clears done", int'(done), 0);
        cfg_int_addr = 14'h0048; cfg_fmt = 2'b11; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        wait_done();
        chk(!ival[8], "R10 busy start ignored", int'(ival[8]), 0);
        chk(ival[2] && ilog[2] == exp_word(2'b01, 22'h000100, 2), "R10 original config kept",
            int'(ilog[2]), int'(exp_word(2'b01, 22'h000100, 2)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_inbound(2'b00, 22'h013FFE, 14'h0100, 3, 0, 0);
        t_inbound(2'b01, 22'h2A3FFF, 14'h0200, 4, 2, 2);
        t_inbound(2'b10, 22'h000050, 14'h0300, 3, 1, 0);
        t_inbound(2'b11, 22'h3F3FFE, 14'h0400, 4, 0, 3);
        t_outbound(2'b00, 22'h053FFD, 14'h0010, 3, 1, 1);
        t_outbound(2'b01, 22'h000200, 14'h0020, 4, 0, 0);
        t_outbound(2'b10, 22'h000300, 14'h0030, 2, 3, 2);
        t_outbound(2'b11, 22'h000400, 14'h0035, 3, 7, 0);
        t_zero();
        t_restart_ignored();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule